// File: doc/BRIEF.md
# SPI Master Burst Shift Engine

This block is the byte-serial shift engine of an SPI master. Software writes a 32-bit control word that holds the clock mode, the bit order, the chip-select setup and a receive-discard switch. Setting the start bit in that word begins a burst. The engine counts a programmed number of bytes on the wire. A separate transmit count sets how many of those bytes are pulled from a transmit FIFO; the remaining bytes are sent as zero. Each received byte is pushed into a receive FIFO unless receive-discard is set. One engine therefore covers full-duplex, transmit-only and dummy-clocked receive-only bursts.

Serial-clock timing comes from an external divider. That divider delivers a one-cycle `sclk_tick` pulse, and each pulse is one SCLK edge. The FIFO storage and the interrupt logic are outside the block. The engine shows a FIFO-facing pop/push interface and a one-cycle `xfer_done` pulse.

Top module: `spi_burst_engine`

## Requirements
- R1: The control word decodes clock phase (CPHA) at bit 0, clock polarity (CPOL) at bit 1, chip-select active level at bit 2 (1 = active high), chip-select index at bits 5:4, manual chip-select at bit 6, manual level at bit 7, receive-discard at bit 8, LSB-first at bit 12 and start at bit 31. All other bits read back as 0.
- R2: Words are 8 bits, sent and received MSB first unless LSB-first is set. With CPHA=0 the first bit is on MOSI before the first SCLK edge and MISO is sampled on leading edges. With CPHA=1 data changes on leading edges and MISO is sampled on trailing edges.
- R3: A burst clocks exactly the burst-count number of bytes (24-bit count). Completion gives one `xfer_done` pulse and clears the start bit one cycle later. A burst count of zero completes without any SCLK activity.
- R4: Exactly min(burst count, transmit count) bytes are popped from the TX FIFO. After that the engine sends 0x00 until the burst ends.
- R5: With receive-discard set, `rx_push` never asserts. Otherwise every clocked byte is pushed.
- R6: In manual mode, the selected chip-select line is the manual level bit. In automatic mode it is at the active level while the start bit is set. Lines that are not selected are always at the inactive level.
- R7: Control writes are ignored while the start bit is set.
- R8: If the TX FIFO is empty while transmit bytes remain, the engine waits with SCLK at CPOL and does not pop.
- R9: SCLK rests at CPOL outside a byte. Each byte takes 16 ticks.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| ctl_wr | input | 1 | Control-word write strobe |
| ctl_wdata | input | 32 | Control word to write |
| ctl_rdata | output | 32 | Current control word |
| burst_len | input | 24 | Total bytes in the burst, sampled at start |
| tx_len | input | 24 | Bytes taken from the TX FIFO, sampled at start |
| sclk_tick | input | 1 | One SCLK edge is due |
| tx_empty | input | 1 | TX FIFO empty |
| tx_data | input | 8 | TX FIFO head byte (valid when not empty) |
| tx_pop | output | 1 | Consume TX FIFO head |
| rx_push | output | 1 | Write `rx_data` into the RX FIFO |
| rx_data | output | 8 | Received byte |
| sclk | output | 1 | Serial clock |
| mosi | output | 1 | Serial data out |
| miso | input | 1 | Serial data in |
| cs_o | output | 4 | Chip-select lines |
| xfer_done | output | 1 | Burst-complete pulse |

## Verification
The hardest case to reach is a transmit stall in the middle of a burst. It needs a FIFO that runs dry before the transmit count is used up, and then refills. The bench's FIFO model exposes only part of its bytes, holds the engine across many tick periods while SCLK is checked at its rest level, and then releases the rest. A behavioural SPI slave follows the clock mode and checks every bit on the wire in all four modes and both bit orders. This includes bursts where the transmit count is zero, partial, or larger than the burst.

// File: rtl/spi_burst_pkg.sv
// Package: control-word field positions, decoded configuration and the
// sequencer state type shared by the SPI burst engine modules.
package spi_burst_pkg;

    localparam int CTL_W       = 32;
    localparam int F_CPHA      = 0;
    localparam int F_CPOL      = 1;
    localparam int F_CS_POL    = 2;
    localparam int F_CS_IDX    = 4;
    localparam int F_CS_MAN    = 6;
    localparam int F_CS_LVL    = 7;
    localparam int F_RX_OFF    = 8;
    localparam int F_LSB_FIRST = 12;
    localparam int F_GO        = 31;

    localparam logic [CTL_W-1:0] CTL_MASK =
        (CTL_W'(1) << F_CPHA) | (CTL_W'(1) << F_CPOL) | (CTL_W'(1) << F_CS_POL) |
        (CTL_W'(3) << F_CS_IDX) | (CTL_W'(1) << F_CS_MAN) | (CTL_W'(1) << F_CS_LVL) |
        (CTL_W'(1) << F_RX_OFF) | (CTL_W'(1) << F_LSB_FIRST) | (CTL_W'(1) << F_GO);

    typedef struct packed {
        logic       cpha;
        logic       cpol;
        logic       cs_pol;
        logic [1:0] cs_idx;
        logic       cs_man;
        logic       cs_lvl;
        logic       rx_off;
        logic       lsb_first;
        logic       go;
    } xfer_cfg_t;

    typedef enum logic [1:0] {SEQ_IDLE, SEQ_FETCH, SEQ_SHIFT} seq_state_t;

    // Splits a control word into its named fields.
    function automatic xfer_cfg_t decode_ctl(input logic [CTL_W-1:0] w);
        xfer_cfg_t c;
        c.cpha      = w[F_CPHA];
        c.cpol      = w[F_CPOL];
        c.cs_pol    = w[F_CS_POL];
        c.cs_idx    = w[F_CS_IDX +: 2];
        c.cs_man    = w[F_CS_MAN];
        c.cs_lvl    = w[F_CS_LVL];
        c.rx_off    = w[F_RX_OFF];
        c.lsb_first = w[F_LSB_FIRST];
        c.go        = w[F_GO];
        return c;
    endfunction

endpackage

// File: rtl/spi_ctl_reg.sv
// Module: spi_ctl_reg
// Holds the control word. A write is accepted only while no burst is active
// (start bit clear). A write carrying the start bit raises start_go for one
// cycle. The start bit is cleared by the sequencer's completion pulse.
// Assumes done_in only pulses while the start bit is set.
module spi_ctl_reg
    import spi_burst_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic [CTL_W-1:0] wr_data,
    input  logic             done_in,
    output logic [CTL_W-1:0] ctl_q,
    output logic             start_go,
    output logic             busy
);

    assign busy     = ctl_q[F_GO];
    assign start_go = wr_en && !busy && wr_data[F_GO];

    // Register update: completion first, then accepted writes.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ctl_q <= '0;
        end else if (done_in) begin
            ctl_q[F_GO] <= 1'b0;
        end else if (wr_en && !busy) begin
            ctl_q <= wr_data & CTL_MASK;
        end
    end

    p_ctl_frozen_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && $past(busy)) |-> $stable(ctl_q[F_GO-1:0]));

    p_go_sets_busy_r3: assert property (@(posedge clk) disable iff (!rst_n)
        start_go |=> busy);

endmodule

// File: rtl/spi_bit_shifter.sv
// Module: spi_bit_shifter
// Serializes one word per load over 2*DATA_W SCLK edges. Each sclk_tick
// gives one edge. The word is normalized for bit order at load, so the
// line always carries the register MSB first. Assumes load only arrives
// while inactive, and that cpol/cpha/lsb_first stay stable during a word.
module spi_bit_shifter #(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cpol,
    input  logic              cpha,
    input  logic              lsb_first,
    input  logic              tick,
    input  logic              load,
    input  logic [DATA_W-1:0] load_data,
    input  logic              miso,
    output logic              sclk,
    output logic              mosi,
    output logic              active,
    output logic              byte_done,
    output logic [DATA_W-1:0] rx_byte
);

    localparam int EDGE_W = $clog2(2 * DATA_W);
    localparam logic [EDGE_W-1:0] LAST_EDGE = EDGE_W'(2 * DATA_W - 1);

    logic              lvl;
    logic [EDGE_W-1:0] ecnt;
    logic [DATA_W-1:0] txsh, rxsh;
    logic [DATA_W-1:0] norm, rx_next, rx_ord;
    logic              lead, samp;

    assign sclk = cpol ^ lvl;

    // Bit-order normalization and edge classification.
    always_comb begin
        for (int i = 0; i < DATA_W; i++) begin
            norm[i] = lsb_first ? load_data[DATA_W-1-i] : load_data[i];
        end
        lead    = !ecnt[0];
        samp    = lead ^ cpha;
        rx_next = samp ? {rxsh[DATA_W-2:0], miso} : rxsh;
        for (int i = 0; i < DATA_W; i++) begin
            rx_ord[i] = lsb_first ? rx_next[DATA_W-1-i] : rx_next[i];
        end
    end

    // Edge engine: load, toggle SCLK, sample and drive per phase.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            active    <= 1'b0;
            lvl       <= 1'b0;
            ecnt      <= '0;
            txsh      <= '0;
            rxsh      <= '0;
            mosi      <= 1'b0;
            byte_done <= 1'b0;
            rx_byte   <= '0;
        end else begin
            byte_done <= 1'b0;
            if (load) begin
                active <= 1'b1;
                ecnt   <= '0;
                lvl    <= 1'b0;
                rxsh   <= '0;
                if (!cpha) begin
                    mosi <= norm[DATA_W-1];
                    txsh <= norm << 1;
                end else begin
                    txsh <= norm;
                end
            end else if (active && tick) begin
                lvl  <= ~lvl;
                ecnt <= ecnt + 1'b1;
                rxsh <= rx_next;
                if (!samp && ecnt != LAST_EDGE) begin
                    mosi <= txsh[DATA_W-1];
                    txsh <= txsh << 1;
                end
                if (ecnt == LAST_EDGE) begin
                    active    <= 1'b0;
                    byte_done <= 1'b1;
                    rx_byte   <= rx_ord;
                end
            end
        end
    end

    p_idle_sclk_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !active |-> (sclk == cpol));

    p_edge_moves_sclk_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (active && tick && !load) |=> (sclk != $past(sclk)));

    p_done_ends_word_r2: assert property (@(posedge clk) disable iff (!rst_n)
        byte_done |-> !active);

endmodule

// File: rtl/spi_burst_seq.sv
// Module: spi_burst_seq
// Byte-level sequencer. It latches the burst and transmit counts at start,
// fetches each byte from the TX FIFO or substitutes zero, hands it to the
// shifter, pushes received bytes and pulses done at the end. Assumes the
// TX FIFO shows its head on tx_data whenever tx_empty is low.
module spi_burst_seq
    import spi_burst_pkg::*;
#(
    parameter int DATA_W = 8,
    parameter int CNT_W  = 24
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start_go,
    input  logic [CNT_W-1:0]  burst_len,
    input  logic [CNT_W-1:0]  tx_len,
    input  logic              rx_off,
    input  logic              tx_empty,
    input  logic [DATA_W-1:0] tx_data,
    output logic              tx_pop,
    output logic              byte_load,
    output logic [DATA_W-1:0] byte_out,
    input  logic              byte_done,
    output logic              rx_push,
    output logic              xfer_done
);

    seq_state_t       state;
    logic [CNT_W-1:0] rem_total, rem_tx;
    logic             have_tx;

    // Fetch decision: FIFO byte while the transmit count lasts, zero after.
    always_comb begin
        have_tx   = (rem_tx != '0);
        byte_load = (state == SEQ_FETCH) && (rem_total != '0) && (!have_tx || !tx_empty);
        tx_pop    = byte_load && have_tx;
        byte_out  = have_tx ? tx_data : '0;
        rx_push   = byte_done && !rx_off && (state == SEQ_SHIFT);
    end

    // Burst state and byte counters.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state     <= SEQ_IDLE;
            rem_total <= '0;
            rem_tx    <= '0;
            xfer_done <= 1'b0;
        end else begin
            xfer_done <= 1'b0;
            case (state)
                SEQ_IDLE: if (start_go) begin
                    rem_total <= burst_len;
                    rem_tx    <= tx_len;
                    state     <= SEQ_FETCH;
                end
                SEQ_FETCH: if (rem_total == '0) begin
                    xfer_done <= 1'b1;
                    state     <= SEQ_IDLE;
                end else if (byte_load) begin
                    if (have_tx) rem_tx <= rem_tx - 1'b1;
                    state <= SEQ_SHIFT;
                end
                SEQ_SHIFT: if (byte_done) begin
                    rem_total <= rem_total - 1'b1;
                    state     <= SEQ_FETCH;
                end
                default: state <= SEQ_IDLE;
            endcase
        end
    end

    p_pop_nonempty_r8: assert property (@(posedge clk) disable iff (!rst_n)
        tx_pop |-> !tx_empty);

    p_discard_no_push_r5: assert property (@(posedge clk) disable iff (!rst_n)
        rx_push |-> !rx_off);

    p_done_single_r3: assert property (@(posedge clk) disable iff (!rst_n)
        xfer_done |=> !xfer_done);

endmodule

// File: rtl/spi_burst_engine.sv
// Module: spi_burst_engine (top)
// SPI master burst shift engine. It ties together the control register,
// the byte sequencer and the bit shifter, and drives the chip-select lines.
// Assumes sclk_tick comes from an external divider, one pulse per SCLK edge.
module spi_burst_engine
    import spi_burst_pkg::*;
#(
    parameter int DATA_W = 8,
    parameter int CNT_W  = 24,
    parameter int CS_N   = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ctl_wr,
    input  logic [31:0]       ctl_wdata,
    output logic [31:0]       ctl_rdata,
    input  logic [CNT_W-1:0]  burst_len,
    input  logic [CNT_W-1:0]  tx_len,
    input  logic              sclk_tick,
    input  logic              tx_empty,
    input  logic [DATA_W-1:0] tx_data,
    output logic              tx_pop,
    output logic              rx_push,
    output logic [DATA_W-1:0] rx_data,
    output logic              sclk,
    output logic              mosi,
    input  logic              miso,
    output logic [CS_N-1:0]   cs_o,
    output logic              xfer_done
);

    localparam int CS_W = $clog2(CS_N);

    logic [CTL_W-1:0]  ctl_q;
    xfer_cfg_t         cfg;
    logic              start_go, busy;
    logic              byte_load, byte_done, shift_active;
    logic [DATA_W-1:0] byte_out;

    assign cfg       = decode_ctl(ctl_q);
    assign ctl_rdata = ctl_q;

    spi_ctl_reg u_ctl (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_en    (ctl_wr),
        .wr_data  (ctl_wdata),
        .done_in  (xfer_done),
        .ctl_q    (ctl_q),
        .start_go (start_go),
        .busy     (busy)
    );

    spi_burst_seq #(.DATA_W(DATA_W), .CNT_W(CNT_W)) u_seq (
        .clk       (clk),
        .rst_n     (rst_n),
        .start_go  (start_go),
        .burst_len (burst_len),
        .tx_len    (tx_len),
        .rx_off    (cfg.rx_off),
        .tx_empty  (tx_empty),
        .tx_data   (tx_data),
        .tx_pop    (tx_pop),
        .byte_load (byte_load),
        .byte_out  (byte_out),
        .byte_done (byte_done),
        .rx_push   (rx_push),
        .xfer_done (xfer_done)
    );

    spi_bit_shifter #(.DATA_W(DATA_W)) u_shift (
        .clk       (clk),
        .rst_n     (rst_n),
        .cpol      (cfg.cpol),
        .cpha      (cfg.cpha),
        .lsb_first (cfg.lsb_first),
        .tick      (sclk_tick),
        .load      (byte_load),
        .load_data (byte_out),
        .miso      (miso),
        .sclk      (sclk),
        .mosi      (mosi),
        .active    (shift_active),
        .byte_done (byte_done),
        .rx_byte   (rx_data)
    );

    // Chip-select drive: manual level or automatic during the burst.
    always_comb begin
        for (int i = 0; i < CS_N; i++) begin
            if (CS_W'(i) == cfg.cs_idx[CS_W-1:0]) begin
                cs_o[i] = cfg.cs_man ? cfg.cs_lvl : (busy ? cfg.cs_pol : !cfg.cs_pol);
            end else begin
                cs_o[i] = !cfg.cs_pol;
            end
        end
    end

    p_auto_cs_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && !cfg.cs_man) |-> ($countones(cs_o ^ {CS_N{!cfg.cs_pol}}) == 1));

    p_shift_needs_busy_r3: assert property (@(posedge clk) disable iff (!rst_n)
        shift_active |-> busy);

endmodule

// File: tb/spi_burst_engine_tb.sv
// Bench: a table of burst vectors walked by one loop, then directed tests.
// It models the TX FIFO, logs RX pushes and runs a behavioural SPI slave.
module spi_burst_engine_tb_top;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        ctl_wr = 1'b0;
    logic [31:0] ctl_wdata = '0;
    logic [31:0] ctl_rdata;
    logic [23:0] burst_len = '0, tx_len = '0;
    logic        sclk_tick = 1'b0;
    logic        tx_empty;
    logic [7:0]  tx_data;
    logic        tx_pop, rx_push, sclk, mosi, xfer_done;
    logic        miso = 1'b0;
    logic [7:0]  rx_data;
    logic [3:0]  cs_o;

    int total = 0, bad = 0, cyc = 0;

    always #4 clk = ~clk;  // 125 MHz

    spi_burst_engine dut_i (
        .clk(clk), .rst_n(rst_n), .ctl_wr(ctl_wr), .ctl_wdata(ctl_wdata),
        .ctl_rdata(ctl_rdata), .burst_len(burst_len), .tx_len(tx_len),
        .sclk_tick(sclk_tick), .tx_empty(tx_empty), .tx_data(tx_data),
        .tx_pop(tx_pop), .rx_push(rx_push), .rx_data(rx_data), .sclk(sclk),
        .mosi(mosi), .miso(miso), .cs_o(cs_o), .xfer_done(xfer_done)
    );

    function automatic logic [7:0] rev8(input logic [7:0] b);
        for (int i = 0; i < 8; i++) rev8[i] = b[7-i];
    endfunction
    function automatic logic [7:0] tx_pat(input int k);
        return 8'h5A ^ 8'(k * 8'h27);
    endfunction
    function automatic logic [7:0] slv_pat(input int k);
        return 8'hC3 ^ 8'(k * 8'h1D);
    endfunction
    function automatic logic slv_bit(input int i);
        logic [7:0] b;
        b = slv_pat(i / 8);
        return b[7 - (i % 8)];
    endfunction

    task automatic check(input bit ok, input string req, input int act, input int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // TX FIFO model: idx advances on an accepted pop.
    int tx_idx = 0, tx_avail = 0, pops = 0;
    assign tx_empty = (tx_idx >= tx_avail);
    assign tx_data  = tx_pat(tx_idx);
    always @(posedge clk) if (tx_pop && !tx_empty) tx_idx <= tx_idx + 1;

    // Tick divider: one tick every 4 cycles.
    int tdiv = 0;
    always @(negedge clk) begin
        tdiv <= (tdiv == 3) ? 0 : tdiv + 1;
        sclk_tick <= (tdiv == 0);
    end

    // Monitors: rx log, pops, done pulses.
    logic [7:0] rx_log [32];
    int rx_n = 0, dones = 0;
    always @(negedge clk) begin
        if (rx_push && rx_n < 32) begin rx_log[rx_n] = rx_data; rx_n++; end
        if (tx_pop) pops++;
        if (xfer_done) dones++;
    end

    // Behavioural slave.
    logic s_cpol = 1'b0, s_cpha = 1'b0, s_prev = 1'b0;
    logic [7:0] s_sh = '0;
    logic [7:0] s_got [32];
    int s_bits = 0, s_nb = 0, s_shifts = 0;
    always @(negedge clk) begin
        if (sclk !== s_prev) begin
            if ((s_prev == s_cpol) != s_cpha) begin
                s_sh = {s_sh[6:0], mosi};
                s_bits++;
                if (s_bits % 8 == 0 && s_nb < 32) begin s_got[s_nb] = s_sh; s_nb++; end
            end else begin
                miso = slv_bit(s_cpha ? s_shifts : s_shifts + 1);
                s_shifts++;
            end
        end
        s_prev = sclk;
    end

    task automatic ctl_write(input logic [31:0] w);
        @(negedge clk); ctl_wr = 1'b1; ctl_wdata = w;
        @(negedge clk); ctl_wr = 1'b0;
    endtask

    task automatic prep(input logic cpol, input logic cpha, input int avail);
        s_cpol = cpol; s_cpha = cpha; s_prev = cpol; s_bits = 0; s_nb = 0;
        s_shifts = 0; miso = cpha ? 1'b0 : slv_bit(0);
        tx_idx = 0; tx_avail = avail; pops = 0; rx_n = 0; dones = 0;
    endtask

    task automatic wait_done();
        for (int i = 0; i < 4000 && dones == 0; i++) @(negedge clk);
        repeat (2) @(negedge clk);
    endtask

    // Burst vectors: [0]cpol [1]cpha [2]lsb [3]discard [11:4]burst [19:12]tx.
    localparam logic [19:0] VEC [7] = '{
        20'h04040, 20'h03033, 20'h01036, 20'h0202D, 20'h00030, 20'h0202F, 20'h05022
    };

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // Reset state.
        check(ctl_rdata == 32'h0, "R1 reset ctl", ctl_rdata, 0);
        check(cs_o == 4'hF && sclk == 1'b0, "R6 reset cs/sclk", {cs_o, 3'b0, sclk}, 8'hF0);
        check(xfer_done == 1'b0 && tx_pop == 1'b0, "R3 reset idle", xfer_done, 0);

        // R1 field map: write all bits except start.
        ctl_write(32'h7FFF_FFFF);
        check(ctl_rdata == 32'h0000_11F7, "R1 field mask", ctl_rdata, 32'h11F7);
        // R6 manual: idx 2, level 0, active-low -> 4'b1011.
        ctl_write(32'h0000_0060);
        check(cs_o == 4'b1011, "R6 manual low", cs_o, 4'b1011);
        ctl_write(32'h0000_00E0);
        check(cs_o == 4'b1111, "R6 manual high", cs_o, 4'b1111);

        // Table walk.
        foreach (VEC[v]) begin
            logic cpol, cpha, lsb, dis;
            int bl, tl, exp_pops;
            logic [31:0] w;
            cpol = VEC[v][0]; cpha = VEC[v][1]; lsb = VEC[v][2]; dis = VEC[v][3];
            bl = int'(VEC[v][11:4]); tl = int'(VEC[v][19:12]);
            exp_pops = (tl < bl) ? tl : bl;
            w = (32'(cpha) << 0) | (32'(cpol) << 1) | (32'(dis) << 8) | (32'(lsb) << 12);
            ctl_write(w);
            prep(cpol, cpha, 8);
            burst_len = 24'(bl); tx_len = 24'(tl);
            ctl_write(w | 32'h8000_0000);
            wait_done();
            check(dones == 1, "R3 one done", dones, 1);
            check(ctl_rdata[31] == 1'b0, "R3 start cleared", ctl_rdata[31], 0);
            check(s_nb == bl, "R3 bytes clocked", s_nb, bl);
            check(pops == exp_pops, "R4 pops", pops, exp_pops);
            check(sclk == cpol, "R9 sclk rest", sclk, cpol);
            for (int k = 0; k < bl && k < s_nb; k++) begin
                logic [7:0] e;
                e = (k < tl) ? (lsb ? rev8(tx_pat(k)) : tx_pat(k)) : 8'h00;
                check(s_got[k] == e, "R2 R4 mosi byte", s_got[k], e);
            end
            check(rx_n == (dis ? 0 : bl), "R5 rx count", rx_n, dis ? 0 : bl);
            for (int k = 0; k < rx_n; k++) begin
                logic [7:0] e;
                e = lsb ? rev8(slv_pat(k)) : slv_pat(k);
                check(rx_log[k] == e, "R2 rx byte", rx_log[k], e);
            end
        end

        // R3 zero-length burst.
        ctl_write(32'h0);
        prep(1'b0, 1'b0, 8);
        burst_len = 0; tx_len = 0;
        ctl_write(32'h8000_0000);
        wait_done();
        check(dones == 1 && s_bits == 0, "R3 zero burst", {dones[7:0], s_bits[7:0]}, 16'h0100);
        check(ctl_rdata[31] == 1'b0, "R3 zero clears start", ctl_rdata[31], 0);

        // R6 auto cs, active high, idx 3; R7 write ignored while busy.
        ctl_write(32'h0000_0034);
        prep(1'b0, 1'b0, 8);
        burst_len = 2; tx_len = 2;
        ctl_write(32'h8000_0034);
        repeat (5) @(negedge clk);
        check(cs_o == 4'b1000, "R6 auto active", cs_o, 4'b1000);
        ctl_write(32'h0000_0103);
        check(ctl_rdata == 32'h8000_0034, "R7 write ignored", ctl_rdata, 32'h80000034);
        wait_done();
        check(cs_o == 4'b0000, "R6 auto release", cs_o, 4'b0000);
        check(ctl_rdata == 32'h0000_0034, "R7 cfg kept", ctl_rdata, 32'h34);

        // R8 stall: only one byte available of three.
        ctl_write(32'h0000_0002);
        prep(1'b1, 1'b0, 1);
        burst_len = 3; tx_len = 3;
        ctl_write(32'h8000_0002);
        repeat (200) @(negedge clk);
        check(pops == 1, "R8 no pop when empty", pops, 1);
        check(sclk == 1'b1, "R8 sclk at cpol in stall", sclk, 1);
        check(dones == 0 && s_nb == 1, "R8 stalled", s_nb, 1);
        tx_avail = 3;
        wait_done();
        check(pops == 3 && s_nb == 3, "R8 resumes", s_nb, 3);
        for (int k = 0; k < 3; k++)
            check(s_got[k] == tx_pat(k), "R8 data after stall", s_got[k], tx_pat(k));

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    // Watchdog.
    always @(posedge clk) begin
        cyc++;
        if (cyc > 150000) begin
            total++; bad++;
            $display("FAIL watchdog actual=%0d expected=%0d", cyc, 150000);
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

endmodule